// File: doc/BRIEF.md
# Bidirectional Modulo-16 Counter

This block is a 4-bit wrapping counter built around an increment-only loadable core. The core can clear, load a parallel word, or step by one. Combinational logic around it adds a down direction. To step down, the logic works out the value one below the current state, modulo 16, and writes it in through the parallel-load path. The core itself never decrements.

Two direction inputs choose the behaviour on each clock:
- 10 counts up.
- 01 counts down.
- 00 or 11 holds the state.

Two terminal flags mark the wrap point of the active direction. A sequencer or timer can use them to cascade a further stage or to detect the end of a cycle. A synchronous clear returns the state to zero whatever the direction inputs are.

Top module: `updown_ctr`

## Requirements
- R1: While rst_n is low, and on the first sample after it rises, cnt_q is 0000 and both terminal flags are 0.
- R2: With dir_up=1, dir_dn=0 and clr=0, cnt_q becomes the old value plus one after the next rising clock edge, and 1111 wraps to 0000.
- R3: With dir_up=0, dir_dn=1 and clr=0, cnt_q becomes the old value minus one after the next rising clock edge, and 0000 wraps to 1111. The new value enters through the core's load path.
- R4: When dir_up equals dir_dn (00 or 11) and clr=0, cnt_q keeps its value across the clock edge.
- R5: clr=1 forces cnt_q to 0000 on the next rising edge, whatever dir_up and dir_dn are. clear takes precedence over load, and load takes precedence over increment.
- R6: tc_up is 1 exactly when dir_up=1, dir_dn=0 and cnt_q=1111. It is combinational and follows the inputs within the same cycle.
- R7: tc_dn is 1 exactly when dir_up=0, dir_dn=1 and cnt_q=0000. It is combinational.
- R8: In either hold encoding, both terminal flags are 0, including at states 0000 and 1111. At most one flag is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear to zero |
| dir_up | input | 1 | Direction input; 1 with dir_dn=0 counts up |
| dir_dn | input | 1 | Direction input; 1 with dir_up=0 counts down |
| cnt_q | output | 4 | Counter state |
| tc_up | output | 1 | Up-direction terminal flag |
| tc_dn | output | 1 | Down-direction terminal flag |

## Verification
The hardest case to reach is a down step that starts from 0000. It exercises the borrow through the load path and the down flag in the same cycle. The stimulus gets there in two ways. It counts down more than sixteen steps in a row. It also issues a clear and then immediately requests a down step.

Both hold encodings are applied while the state sits at 0000 and at 1111. This shows that neither flag leaks outside its own direction. A long stretch of random direction and clear patterns then compares the state and both flags against a behavioural model on every cycle.

// File: rtl/updown_ctr.sv
module updown_ctr #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             dir_up,
  input  logic             dir_dn,
  output logic [WIDTH-1:0] cnt_q,
  output logic             tc_up,
  output logic             tc_dn
);
  localparam logic [WIDTH-1:0] ALL_ONE = '1;
  localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

  logic             go_up, go_dn;
  logic             core_ld, core_inc;
  logic [WIDTH-1:0] core_din;

  assign go_up    = dir_up & ~dir_dn;
  assign go_dn    = dir_dn & ~dir_up;

  assign core_inc = go_up;
  assign core_ld  = go_dn;
  assign core_din = cnt_q - ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (core_ld)  cnt_q <= core_din;
    else if (core_inc) cnt_q <= cnt_q + ONE;
  end

  assign tc_up = go_up & (cnt_q == ALL_ONE);
  assign tc_dn = go_dn & (cnt_q == '0);
endmodule

module updown_ctr_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             dir_up,
  input logic             dir_dn,
  input logic [WIDTH-1:0] cnt_q,
  input logic             tc_up,
  input logic             tc_dn
);
  assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_up && !dir_dn && !clr) |=> cnt_q == WIDTH'($past(cnt_q) + 1'b1));
  assert_dn_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_dn && !dir_up && !clr) |=> cnt_q == WIDTH'($past(cnt_q) - 1'b1));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_up == dir_dn && !clr) |=> $stable(cnt_q));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
  assert_tc_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc_up |-> (dir_up && !dir_dn && &cnt_q));
  assert_tc_dn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_dn |-> (dir_dn && !dir_up && cnt_q == '0));
  assert_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tc_up, tc_dn}));
endmodule

bind updown_ctr updown_ctr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/updown_ctr_tb.sv
module updown_ctr_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       dir_up = 1'b0;
  logic       dir_dn = 1'b0;
  logic [3:0] cnt_q;
  logic       tc_up, tc_dn;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  updown_ctr #(.WIDTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .dir_up(dir_up), .dir_dn(dir_dn),
    .cnt_q(cnt_q), .tc_up(tc_up), .tc_dn(tc_dn)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit c, input bit u, input bit d);
    string sreq, treq;
    int eu, ed;
    clr = c; dir_up = u; dir_dn = d;
    #1;
    eu = (u && !d && model == 15) ? 1 : 0;
    ed = (d && !u && model == 0) ? 1 : 0;
    treq = (u == d) ? "R8" : (u ? "R6" : "R7");
    check({treq, " tc_up"}, int'(tc_up), eu);
    check({treq, " tc_dn"}, int'(tc_dn), ed);
    @(posedge clk);
    if (c) begin model = 0; sreq = "R5"; end
    else if (u && !d) begin model = (model + 1) % 16; sreq = "R2"; end
    else if (d && !u) begin model = (model + 15) % 16; sreq = "R3"; end
    else sreq = "R4";
    @(negedge clk);
    check({sreq, " cnt_q"}, int'(cnt_q), model);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cnt_q in reset", int'(cnt_q), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cnt_q", int'(cnt_q), 0);
    check("R1 tc_up", int'(tc_up), 0);
    check("R1 tc_dn", int'(tc_dn), 0);
    model = 0;

    for (int i = 0; i < 15; i++) step(0, 1, 0);
    step(0, 0, 0); step(0, 1, 1);
    step(0, 1, 0);
    step(0, 1, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 1);
    step(0, 1, 0); step(1, 0, 1);
    step(0, 0, 0); step(0, 1, 1);
    step(0, 0, 1);
    step(0, 1, 0); step(0, 1, 0); step(1, 1, 0);
    step(0, 0, 1);
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 15);
      step(r == 0, r[1], r[2]);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule